// File: doc/BRIEF.md
# Write-Busy Status Read Path

This block builds the byte a host sees when it reads a byte-wide non-volatile memory that may be in the middle of an internal write. It sits between the storage array and the data pins. It watches the chip-select, output-enable and write-enable lines, the address, a busy flag from the write sequencer, and the address and polling bit of the byte most recently written. All of these are sampled on a system clock.

While busy is low, a read returns the stored byte unchanged. While busy is high, the block reports progress in two ways. The top data bit of a read at the last-written address returns the inverse of the bit that was written there. Bit 6 of every read returns a toggle state that inverts after each completed read. When busy drops, the toggle state is cleared and true data comes back on every bit. The output byte and its drive enable are registered, so a read sampled at one clock edge is presented after that edge.

The host can start polling by either method at any point during the write. Storing the array and sequencing the write are handled elsewhere.

Top module: `wbusy_rdpath`

## Requirements
- R1: A read is sampled at a rising clock edge when ce_n=0, oe_n=0 and we_n=1. After that edge dq_oe_o is 1 and dq_o carries the composed byte.
- R2: After any edge where ce_n=1 or oe_n=1, dq_oe_o is 0 and dq_o is all zero, which stands for the high-impedance state.
- R3: While busy_i=1, a read at addr_i equal to last_addr_i returns the inverse of last_msb_i on data bit 7.
- R4: While busy_i=1, data bit 6 of a read returns the toggle state. The toggle state is 0 for the first read after busy_i rises, and it inverts after each completed read, meaning the cycle in which a sampled read becomes inactive.
- R5: While busy_i=1, bits 5..0 return arr_data_i. A read at an address other than last_addr_i returns arr_data_i bit 7 on data bit 7.
- R6: While busy_i=0, a read returns arr_data_i on all bits.
- R7: At each clock edge with busy_i=0, the toggle state is cleared to 0, so toggling stops when the write completes and restarts from 0 on the next write.
- R8: A write access (we_n=0) or a cycle with the outputs disabled does not invert the toggle state.
- R9: After reset, dq_oe_o=0, dq_o=0 and the toggle state is 0.
- R10: While busy_i=1, reads at addresses other than last_addr_i still return the toggle state on bit 6 and still advance it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr_i | input | ADDR_W | Read address |
| busy_i | input | 1 | Internal write in progress |
| last_addr_i | input | ADDR_W | Address of the most recently written byte |
| last_msb_i | input | 1 | Bit 7 of the most recently written byte |
| arr_data_i | input | DATA_W | Stored byte at addr_i |
| dq_o | output | DATA_W | Read data, zero when not driven |
| dq_oe_o | output | 1 | Data pin drive enable |

## Verification
The bench reads the last-written address with both polarities of the written bit. A design that passes the stored bit through, or inverts the wrong bit, would show a mismatch on bit 7. It also reads other addresses during busy, where bit 6 must keep toggling and bit 7 must stay true. A design that tied the toggle to the address match would stop toggling there. Write cycles and disabled cycles are placed between reads, and busy is dropped while the toggle is at 1. A design that counted those cycles, or kept a stale toggle state into the next write, would read a wrong bit 6.

// File: rtl/wbr_pkg.sv
// Shared types for the write-busy read path.
// Assumes the bus control lines are already synchronous to clk.
package wbr_pkg;

    // Kind of access presented on the control lines in one cycle.
    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_kind_e;

    // Classify the control lines into an access kind.
    function automatic acc_kind_e classify(input logic ce_n, input logic oe_n,
                                           input logic we_n);
        acc_kind_e k;
        k = ACC_IDLE;
        if (!ce_n && !we_n && oe_n)
            k = ACC_WRITE;
        else if (!ce_n && !oe_n && we_n)
            k = ACC_READ;
        return k;
    endfunction

endpackage

// File: rtl/wbr_access_decode.sv
// Decodes the bus control lines into a read-active flag and a one-cycle
// pulse marking the end of a read (active -> inactive).
// Assumes: control inputs stable around the rising clock edge.
module wbr_access_decode
    import wbr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic oe_n,
    input  logic we_n,
    output logic rd_act,
    output logic rd_end
);

    acc_kind_e kind;
    logic      rd_prev_q;

    // Classify the current cycle.
    always_comb kind = classify(ce_n, oe_n, we_n);

    assign rd_act = (kind == ACC_READ);

    // Remember whether the previous cycle was a read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_prev_q <= 1'b0;
        else
            rd_prev_q <= rd_act;
    end

    assign rd_end = rd_prev_q && !rd_act;

endmodule

// File: rtl/wbr_toggle_state.sv
// Holds the progress toggle reported during an internal write.
// Inverts on each completed read while busy; cleared whenever busy is low.
// Assumes: rd_end is a single-cycle pulse from the access decoder.
module wbr_toggle_state (
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    input  logic rd_end,
    output logic tog
);

    logic tog_q;

    // Advance or clear the toggle state.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tog_q <= 1'b0;
        else if (!busy)
            tog_q <= 1'b0;
        else if (rd_end)
            tog_q <= ~tog_q;
    end

    assign tog = tog_q;

endmodule

// File: rtl/wbr_byte_compose.sv
// Builds the read byte: true array data when idle; during busy the
// polling bit shows the inverse written bit on an address match and the
// toggle bit shows the toggle state.
// Assumes: POLL_BIT and TGL_BIT are distinct and inside the byte.
module wbr_byte_compose #(
    parameter int DATA_W   = 8,
    parameter int ADDR_W   = 17,
    parameter int POLL_BIT = DATA_W - 1,
    parameter int TGL_BIT  = DATA_W - 2
) (
    input  logic              busy,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] last_addr,
    input  logic              last_msb,
    input  logic              tog,
    input  logic [DATA_W-1:0] arr_data,
    output logic [DATA_W-1:0] byte_o
);

    logic hit;

    // Match against the last written location.
    always_comb hit = (addr == last_addr);

    for (genvar gi = 0; gi < DATA_W; gi++) begin : g_bit
        if (gi == POLL_BIT) begin : g_poll
            assign byte_o[gi] = (busy && hit) ? ~last_msb : arr_data[gi];
        end else if (gi == TGL_BIT) begin : g_tgl
            assign byte_o[gi] = busy ? tog : arr_data[gi];
        end else begin : g_pass
            assign byte_o[gi] = arr_data[gi];
        end
    end

endmodule

// File: rtl/wbusy_rdpath.sv
// Top of the write-busy read path. Registers the composed byte and the
// drive enable once per clock from the sampled bus control lines.
// Assumes: arr_data_i is the stored byte for the current addr_i.
module wbusy_rdpath #(
    parameter int DATA_W   = 8,
    parameter int ADDR_W   = 17,
    parameter int POLL_BIT = DATA_W - 1,
    parameter int TGL_BIT  = DATA_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              busy_i,
    input  logic [ADDR_W-1:0] last_addr_i,
    input  logic              last_msb_i,
    input  logic [DATA_W-1:0] arr_data_i,
    output logic [DATA_W-1:0] dq_o,
    output logic              dq_oe_o
);

    logic              rd_act;
    logic              rd_end;
    logic              tog_q;
    logic [DATA_W-1:0] byte_c;
    logic [DATA_W-1:0] dq_q;
    logic              oe_q;

    wbr_access_decode u_dec (
        .clk    (clk),
        .rst_n  (rst_n),
        .ce_n   (ce_n),
        .oe_n   (oe_n),
        .we_n   (we_n),
        .rd_act (rd_act),
        .rd_end (rd_end)
    );

    wbr_toggle_state u_tog (
        .clk    (clk),
        .rst_n  (rst_n),
        .busy   (busy_i),
        .rd_end (rd_end),
        .tog    (tog_q)
    );

    wbr_byte_compose #(
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W),
        .POLL_BIT (POLL_BIT),
        .TGL_BIT  (TGL_BIT)
    ) u_cmp (
        .busy      (busy_i),
        .addr      (addr_i),
        .last_addr (last_addr_i),
        .last_msb  (last_msb_i),
        .tog       (tog_q),
        .arr_data  (arr_data_i),
        .byte_o    (byte_c)
    );

    // Register the output byte and its drive enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dq_q <= '0;
            oe_q <= 1'b0;
        end else begin
            oe_q <= rd_act;
            dq_q <= rd_act ? byte_c : '0;
        end
    end

    assign dq_o    = dq_q;
    assign dq_oe_o = oe_q;

endmodule

// File: rtl/wbusy_rdpath_chk.sv
// Checker for wbusy_rdpath, attached by bind. Watches ports plus the
// toggle state and read-end pulse driven by separate submodules.
module wbusy_rdpath_chk #(
    parameter int DATA_W   = 8,
    parameter int ADDR_W   = 17,
    parameter int POLL_BIT = DATA_W - 1,
    parameter int TGL_BIT  = DATA_W - 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_n,
    input logic              oe_n,
    input logic              we_n,
    input logic [ADDR_W-1:0] addr_i,
    input logic              busy_i,
    input logic [ADDR_W-1:0] last_addr_i,
    input logic              last_msb_i,
    input logic [DATA_W-1:0] arr_data_i,
    input logic [DATA_W-1:0] dq_o,
    input logic              dq_oe_o,
    input logic              tog_q,
    input logic              rd_end
);

    logic is_rd;
    always_comb is_rd = !ce_n && !oe_n && we_n;

    // R1
    a_r1_drive: assert property (@(posedge clk) disable iff (!rst_n)
        is_rd |=> dq_oe_o);

    // R2
    a_r2_hiz: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n || oe_n) |=> (!dq_oe_o && dq_o == '0));

    // R3
    a_r3_poll_inv: assert property (@(posedge clk) disable iff (!rst_n)
        (is_rd && busy_i && addr_i == last_addr_i)
        |=> dq_o[POLL_BIT] == !$past(last_msb_i));

    // R4
    a_r4_flip: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && rd_end) |=> tog_q != $past(tog_q));

    // R5
    a_r5_true_msb: assert property (@(posedge clk) disable iff (!rst_n)
        (is_rd && busy_i && addr_i != last_addr_i)
        |=> dq_o[POLL_BIT] == $past(arr_data_i[POLL_BIT]));

    // R6
    a_r6_true_data: assert property (@(posedge clk) disable iff (!rst_n)
        (is_rd && !busy_i) |=> dq_o == $past(arr_data_i));

    // R7
    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_i |=> !tog_q);

    // R8
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && !rd_end) |=> $stable(tog_q));

endmodule

bind wbusy_rdpath wbusy_rdpath_chk #(
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .POLL_BIT (POLL_BIT),
    .TGL_BIT  (TGL_BIT)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ce_n        (ce_n),
    .oe_n        (oe_n),
    .we_n        (we_n),
    .addr_i      (addr_i),
    .busy_i      (busy_i),
    .last_addr_i (last_addr_i),
    .last_msb_i  (last_msb_i),
    .arr_data_i  (arr_data_i),
    .dq_o        (dq_o),
    .dq_oe_o     (dq_oe_o),
    .tog_q       (tog_q),
    .rd_end      (rd_end)
);

// File: tb/wbusy_rdpath_tb.sv
module wbusy_rdpath_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;
    localparam int AW = 17;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [AW-1:0] addr_i = '0;
    logic          busy_i = 1'b0;
    logic [AW-1:0] last_addr_i = '0;
    logic          last_msb_i = 1'b0;
    logic [DW-1:0] arr_data_i = '0;
    logic [DW-1:0] dq_o;
    logic          dq_oe_o;

    int checks = 0;
    int failures = 0;
    logic tb_tog = 1'b0;
    logic [DW-1:0] exp_q[$];
    string tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    wbusy_rdpath #(.DATA_W(DW), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr_i(addr_i), .busy_i(busy_i), .last_addr_i(last_addr_i),
        .last_msb_i(last_msb_i), .arr_data_i(arr_data_i),
        .dq_o(dq_o), .dq_oe_o(dq_oe_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Driver: one read cycle then one idle cycle; pushes the expected byte.
    task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] d, input string req);
        logic [DW-1:0] e;
        e = d;
        if (busy_i) begin
            if (a == last_addr_i) e[7] = ~last_msb_i;
            e[6] = tb_tog;
            tb_tog = ~tb_tog;
        end
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr_i = a; arr_data_i = d;
        exp_q.push_back(e);
        tag_q.push_back(req);
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    // Non-read cycle: write access or outputs disabled; must not drive.
    task automatic nonrd(input logic c, input logic o, input logic w, input string req);
        @(negedge clk);
        ce_n = c; oe_n = o; we_n = w; arr_data_i = 8'hFF;
        @(negedge clk);
        check(!dq_oe_o && dq_o == '0, req, {dq_oe_o, dq_o}, 0);
        ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    endtask

    task automatic set_busy(input logic b);
        @(negedge clk);
        busy_i = b;
        if (!b) tb_tog = 1'b0;
    endtask

    // Monitor: pops and compares each driven byte.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && dq_oe_o) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2 unexpected drive", dq_o, 0);
                end else begin
                    logic [DW-1:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(dq_o == e, t, dq_o, e);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] lf;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!dq_oe_o && dq_o == '0, "R9 reset", {dq_oe_o, dq_o}, 0);

        // Idle reads return true data.
        rd(17'h00005, 8'hA5, "R6 R1 idle read");
        rd(17'h00100, 8'h7C, "R6 idle read at last addr");
        nonrd(1'b0, 1'b1, 1'b1, "R2 oe_n high");
        nonrd(1'b1, 1'b0, 1'b1, "R2 ce_n high");

        // Write in progress, written bit 7 = 1.
        last_addr_i = 17'h00100; last_msb_i = 1'b1;
        set_busy(1'b1);
        rd(17'h00100, 8'h3F, "R3 R4 first poll");
        rd(17'h00100, 8'hBF, "R3 R4 second poll");
        rd(17'h00022, 8'hC5, "R5 R10 other addr");
        rd(17'h00022, 8'h15, "R10 other addr toggles");
        nonrd(1'b0, 1'b1, 1'b0, "R8 R2 write cycle");
        nonrd(1'b1, 1'b0, 1'b1, "R8 disabled cycle");
        rd(17'h00100, 8'h00, "R8 toggle held");
        last_msb_i = 1'b0;
        rd(17'h00100, 8'hFF, "R3 inverse of zero");
        rd(17'h00100, 8'h5A, "R5 low bits true");

        // Complete with toggle at 1, then restart.
        set_busy(1'b0);
        rd(17'h00100, 8'h96, "R7 R6 true after done");
        rd(17'h00100, 8'h69, "R7 no toggling after done");
        set_busy(1'b1);
        rd(17'h00033, 8'hFF, "R7 restart from zero");

        // Longer mixed run.
        lf = 8'h5B;
        for (int i = 0; i < 24; i++) begin
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            if (i == 12) set_busy(1'b0);
            if (i == 15) set_busy(1'b1);
            if (i % 5 == 2) nonrd(1'b0, 1'b1, 1'b0, "R8 write in run");
            rd((i % 3 == 0) ? 17'h00100 : {9'h0, lf}, lf, "R4 R10 run");
        end
        set_busy(1'b0);
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R1 all reads driven", exp_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule